// File: doc/BRIEF.md
# 10BASE-T Receive Polarity Corrector

This block decides whether the receive twisted pair of a 10BASE-T port is wired with its two conductors swapped, and undoes the swap on the received data bit. An upstream classifier watches the line. It strobes one of four inputs for each event it sees: a link pulse of normal sense, a link pulse of inverted sense, an end-of-frame marker of normal sense, or an end-of-frame marker of inverted sense. The block counts unbroken runs of inverted events of each kind. A long enough run of either kind switches the port to inverted polarity.

While the port is inverted, the received data bit is flipped on its way out and a status flag is high. Inverted polarity is held until the line has been quiet for a fixed receive timeout, measured with a millisecond tick. The port then returns to normal polarity and waits to learn the wiring again. Slicing of the line and classification of pulses and markers are done elsewhere.

Top module: `rx_polarity_fix`

## Requirements
- R1: Eight inverted link-pulse strobes with no normal link-pulse strobe between them set the polarity state to inverted, and `pol_rev_o` is 1 from the clock edge that registers the eighth strobe. Seven do not.
- R2: Four inverted end-of-frame strobes with no normal end-of-frame strobe between them set the polarity state to inverted, and `pol_rev_o` is 1 from the clock edge that registers the fourth strobe. Three do not.
- R3: A normal link-pulse strobe restarts the inverted link-pulse run from zero. A normal end-of-frame strobe restarts the inverted end-of-frame run from zero.
- R4: `rx_data_o` equals `rx_data_i` in the same cycle while the state is normal, and equals its complement while the state is inverted.
- R5: 112 `ms_tick_i` pulses with no strobe and no `rx_active_i` return the state to normal. `pol_rev_o` falls on the edge that registers the 112th such tick. 111 such ticks leave the state unchanged.
- R6: Any strobe, or `rx_active_i` high, restarts the quiet-time count. A tick that arrives in a cycle that also has activity is not counted.
- R7: Once the state is inverted, it is held until the timeout or reset. Raw normal-sense strobes of either kind, in any number, do not return it to normal.
- R8: The timeout also discards partial runs. After seven inverted link pulses followed by the timeout, one more inverted link pulse leaves the state normal.
- R9: After reset, `pol_rev_o` is 0 and `rx_data_o` follows `rx_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lp_norm_i | input | 1 | Strobe: link pulse of normal sense |
| lp_inv_i | input | 1 | Strobe: link pulse of inverted sense |
| eof_norm_i | input | 1 | Strobe: end-of-frame marker of normal sense |
| eof_inv_i | input | 1 | Strobe: end-of-frame marker of inverted sense |
| rx_active_i | input | 1 | Receive activity present |
| ms_tick_i | input | 1 | One-cycle pulse each millisecond |
| rx_data_i | input | 1 | Raw received data bit |
| rx_data_o | output | 1 | Polarity-corrected data bit |
| pol_rev_o | output | 1 | High while reversed polarity is in force |

## Verification
The bench stops runs one event short of the threshold and breaks runs with a single normal event. An off-by-one counter would declare reversal too early, and a missing clear would declare it across a break. It runs the quiet timer to 111 and then 112 ticks, and inserts activity that lands on a tick, so a timer that miscounts, ignores activity, or counts a tick that comes with activity shows up as a flag that falls at the wrong moment. It also sends raw normal-sense events while the state is inverted. It then times out after a partial run to expose a design that releases the held state early or keeps stale counts.

// File: rtl/rxpol_pkg.sv
package rxpol_pkg;
  typedef enum logic {
    POL_NORMAL   = 1'b0,
    POL_INVERTED = 1'b1
  } pol_e;
endpackage

// File: rtl/rxpol_run_cnt.sv
// Counts consecutive hits; a miss restarts; full_o pulses on the THRESH-th hit.
module rxpol_run_cnt #(
  parameter int unsigned THRESH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic hit_i,
  input  logic miss_i,
  output logic full_o
);
  localparam int unsigned W = $clog2(THRESH + 1);
  localparam logic [W-1:0] LAST = W'(THRESH - 1);

  logic [W-1:0] cnt_q;

  assign full_o = hit_i && !miss_i && !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i || miss_i)    cnt_q <= '0;
    else if (full_o)             cnt_q <= '0;
    else if (hit_i)              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rxpol_idle_timer.sv
// Counts ms ticks without activity; expire_o pulses on the LIMIT-th quiet tick.
module rxpol_idle_timer #(
  parameter int unsigned LIMIT = 112
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign expire_o = tick_i && !act_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (act_i)           cnt_q <= '0;
    else if (expire_o)        cnt_q <= '0;
    else if (tick_i)          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rx_polarity_fix.sv
module rx_polarity_fix
  import rxpol_pkg::*;
#(
  parameter int unsigned LP_RUN     = 8,
  parameter int unsigned EOF_RUN    = 4,
  parameter int unsigned TIMEOUT_MS = 112
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lp_norm_i,
  input  logic lp_inv_i,
  input  logic eof_norm_i,
  input  logic eof_inv_i,
  input  logic rx_active_i,
  input  logic ms_tick_i,
  input  logic rx_data_i,
  output logic rx_data_o,
  output logic pol_rev_o
);
  pol_e state_q;
  logic inv;
  logic any_act, expire;
  logic lp_hit, lp_miss, eof_hit, eof_miss;
  logic lp_full, eof_full;

  assign inv     = (state_q == POL_INVERTED);
  assign any_act = lp_norm_i | lp_inv_i | eof_norm_i | eof_inv_i | rx_active_i;

  // compare in corrected sense: once inverted, raw "normal" reads as inverted
  assign lp_hit   = inv ? lp_norm_i  : lp_inv_i;
  assign lp_miss  = inv ? lp_inv_i   : lp_norm_i;
  assign eof_hit  = inv ? eof_norm_i : eof_inv_i;
  assign eof_miss = inv ? eof_inv_i  : eof_norm_i;

  rxpol_run_cnt #(.THRESH(LP_RUN)) u_lp_run (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (expire),
    .hit_i  (lp_hit),
    .miss_i (lp_miss),
    .full_o (lp_full)
  );

  rxpol_run_cnt #(.THRESH(EOF_RUN)) u_eof_run (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (expire),
    .hit_i  (eof_hit),
    .miss_i (eof_miss),
    .full_o (eof_full)
  );

  rxpol_idle_timer #(.LIMIT(TIMEOUT_MS)) u_idle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .act_i    (any_act),
    .tick_i   (ms_tick_i),
    .expire_o (expire)
  );

  // declaration only moves normal -> inverted; held until timeout
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                state_q <= POL_NORMAL;
    else if (expire)                            state_q <= POL_NORMAL;
    else if (!inv && (lp_full || eof_full))     state_q <= POL_INVERTED;
  end

  assign pol_rev_o = inv;
  assign rx_data_o = rx_data_i ^ inv;
endmodule

// File: rtl/rxpol_checker.sv
module rxpol_checker #(
  parameter int unsigned TIMEOUT_MS = 112
) (
  input logic clk_i,
  input logic rst_ni,
  input logic lp_norm_i,
  input logic lp_inv_i,
  input logic eof_norm_i,
  input logic eof_inv_i,
  input logic rx_active_i,
  input logic ms_tick_i,
  input logic rx_data_i,
  input logic rx_data_o,
  input logic pol_rev_o
);
  localparam int unsigned W = $clog2(TIMEOUT_MS + 1);
  logic act;
  logic [W-1:0] quiet_q;

  assign act = lp_norm_i | lp_inv_i | eof_norm_i | eof_inv_i | rx_active_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                        quiet_q <= '0;
    else if (act)                                       quiet_q <= '0;
    else if (ms_tick_i && quiet_q != W'(TIMEOUT_MS))    quiet_q <= quiet_q + 1'b1;
  end

  // R1 R2: reversal only follows an inverted-sense strobe
  a_r1_rise_needs_inv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pol_rev_o) |-> $past(lp_inv_i || eof_inv_i));

  // R4
  a_r4_data_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pol_rev_o |-> (rx_data_o != rx_data_i));
  a_r4_data_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pol_rev_o |-> (rx_data_o == rx_data_i));

  // R5: after the full quiet window the flag must be low
  a_r5_timeout_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_q == W'(TIMEOUT_MS)) |-> !pol_rev_o);

  // R6: fall only on a quiet tick
  a_r6_fall_on_quiet_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pol_rev_o) |-> $past(ms_tick_i && !act));

  // R7: held without a tick
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_rev_o && !ms_tick_i) |=> pol_rev_o);
endmodule

bind rx_polarity_fix rxpol_checker #(.TIMEOUT_MS(TIMEOUT_MS)) u_rxpol_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lp_norm_i   (lp_norm_i),
  .lp_inv_i    (lp_inv_i),
  .eof_norm_i  (eof_norm_i),
  .eof_inv_i   (eof_inv_i),
  .rx_active_i (rx_active_i),
  .ms_tick_i   (ms_tick_i),
  .rx_data_i   (rx_data_i),
  .rx_data_o   (rx_data_o),
  .pol_rev_o   (pol_rev_o)
);

// File: tb/rx_polarity_fix_test.sv
module rx_polarity_fix_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lp_norm = 0, lp_inv = 0, eof_norm = 0, eof_inv = 0;
  logic rx_act = 0, tick = 0, din = 0;
  logic dout, pol;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rx_polarity_fix uut (
    .clk_i(clk), .rst_ni(rst_n),
    .lp_norm_i(lp_norm), .lp_inv_i(lp_inv),
    .eof_norm_i(eof_norm), .eof_inv_i(eof_inv),
    .rx_active_i(rx_act), .ms_tick_i(tick),
    .rx_data_i(din), .rx_data_o(dout), .pol_rev_o(pol)
  );

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // kind: 0 lp normal, 1 lp inverted, 2 eof normal, 3 eof inverted
  task automatic send(int kind, int n);
    for (int i = 0; i < n; i++) begin
      lp_norm = (kind == 0); lp_inv = (kind == 1);
      eof_norm = (kind == 2); eof_inv = (kind == 3);
      @(negedge clk);
      {lp_norm, lp_inv, eof_norm, eof_inv} = '0;
      @(negedge clk);
    end
  endtask

  task automatic ticks(int n, logic with_act);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; rx_act = with_act;
      @(negedge clk);
      tick = 1'b0; rx_act = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_reset();
    check("R9 flag", pol, 1'b0);
    din = 1'b1; #1;
    check("R9 data", dout, 1'b1);
    din = 1'b0;
  endtask

  task automatic t_lp_run();
    do_reset();
    send(1, 7);
    check("R1 seven", pol, 1'b0);
    lp_inv = 1'b1;
    @(negedge clk);
    check("R1 eighth", pol, 1'b1);
    lp_inv = 1'b0;
  endtask

  task automatic t_eof_run();
    do_reset();
    send(3, 3);
    check("R2 three", pol, 1'b0);
    send(3, 1);
    check("R2 fourth", pol, 1'b1);
  endtask

  task automatic t_breaks();
    do_reset();
    send(1, 7); send(0, 1); send(1, 7);
    check("R3 lp break", pol, 1'b0);
    send(3, 3); send(2, 1); send(3, 3);
    check("R3 eof break", pol, 1'b0);
    send(1, 1);
    check("R3 lp run resumes", pol, 1'b1);
  endtask

  task automatic t_data();
    do_reset();
    din = 1'b1; #1; check("R4 pass 1", dout, 1'b1);
    din = 1'b0; #1; check("R4 pass 0", dout, 1'b0);
    send(3, 4);
    din = 1'b1; #1; check("R4 flip 1", dout, 1'b0);
    din = 1'b0; #1; check("R4 flip 0", dout, 1'b1);
  endtask

  task automatic t_timeout();
    do_reset();
    send(3, 4);
    ticks(111, 1'b0);
    check("R5 at 111", pol, 1'b1);
    ticks(1, 1'b0);
    check("R5 at 112", pol, 1'b0);
  endtask

  task automatic t_restart();
    do_reset();
    send(1, 8);
    ticks(100, 1'b0);
    send(0, 1);
    ticks(111, 1'b0);
    check("R6 strobe restart", pol, 1'b1);
    ticks(1, 1'b1);
    ticks(111, 1'b0);
    check("R6 tick with activity", pol, 1'b1);
    ticks(1, 1'b0);
    check("R6 expire", pol, 1'b0);
  endtask

  task automatic t_hold();
    do_reset();
    send(1, 8);
    send(0, 16);
    check("R7 raw normal lp", pol, 1'b1);
    send(2, 8);
    check("R7 raw normal eof", pol, 1'b1);
    send(1, 8);
    check("R7 raw inverted lp", pol, 1'b1);
  endtask

  task automatic t_stale();
    do_reset();
    send(1, 7);
    ticks(112, 1'b0);
    send(1, 1);
    check("R8 stale lp run", pol, 1'b0);
    send(1, 7);
    check("R8 fresh run", pol, 1'b1);
  endtask

  initial begin
    t_reset();
    t_lp_run();
    t_eof_run();
    t_breaks();
    t_data();
    t_timeout();
    t_restart();
    t_hold();
    t_stale();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule